// File: doc/BRIEF.md
# Receive Virtual-Channel Buffer with Watermark Backpressure

This block holds the frames of one virtual channel as they arrive from the link layer and hands them on, whole and in order, to the frame decoder. Frames vary in length and are written into a circular word store back to back, so a short frame takes only as many words as it carries. The input stream has no ready signal; flow control runs through a pause output. Pause rises once the number of stored words passes a high watermark and falls only after that number has dropped below a low watermark.

The store is sized as a number of maximum-length frames plus two round trips of data. By default the high mark sits one round trip below the top, and the low mark at one round trip. The space above the high mark absorbs words that are already in flight when pause goes out. Both marks are inputs counted in words. A high mark that would leave less than one round trip of headroom is clamped. A build parameter selects the multicast sizing, which uses 8 maximum frames in place of 32. If a word arrives while the store is full, the whole frame it belongs to is discarded, any of its words already stored are released again, and a sticky overflow flag is raised.

Top module: `rxvc_wm_buffer`

## Requirements
- R1: After reset, out_valid, pause and overflow are all 0.
- R2: Frames leave in arrival order. Each word keeps its data, and out_last is 1 exactly on the final word of a frame. A word leaves on a cycle where out_valid and out_ready are both 1.
- R3: No word of a frame is offered at the output until the frame's last word has been stored. Once the first word of a frame is offered, the remaining words follow with out_valid held at 1.
- R4: Occupancy is the number of stored words, counting the words of a frame that is still incomplete. Pause goes to 1 on the clock edge after the edge at which occupancy exceeds the effective high mark.
- R5: Once pause is 1, it stays at 1 until the edge after occupancy is below cfg_lo_wm, and it then returns to 0.
- R6: The effective high mark is cfg_hi_wm limited to DEPTH - RTT_WORDS. With default parameters, that limit is 288 words.
- R7: A word that arrives while occupancy equals DEPTH causes its whole frame to be discarded: the words of that frame already stored are released, and the rest of the frame up to its last word is ignored. overflow becomes 1 and stays at 1 until reset. Frames stored earlier and frames that arrive later pass through unchanged.
- R8: DEPTH is FRAMES * MAX_FRAME_WORDS + 2 * RTT_WORDS words, with FRAMES set to 32, or to 8 when MCAST is 1. Frames are packed without padding, so any mix of frame lengths totalling DEPTH words is stored with no overflow. The default DEPTH is 320.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Incoming word is present this cycle |
| in_data | input | DATA_W | Incoming word |
| in_last | input | 1 | Incoming word ends its frame |
| out_valid | output | 1 | A stored word of a complete frame is offered |
| out_ready | input | 1 | Consumer takes the offered word |
| out_data | output | DATA_W | Offered word |
| out_last | output | 1 | Offered word ends its frame |
| cfg_hi_wm | input | CW | High watermark in words |
| cfg_lo_wm | input | CW | Low watermark in words |
| pause | output | 1 | Backpressure request to the sender |
| overflow | output | 1 | Sticky flag: a frame was dropped because the store was full |

## Verification
The assertions assume that the sender ends every frame with in_last, that no frame is longer than MAX_FRAME_WORDS, that the watermark inputs stay constant apart from changes made while the store is empty, and that cfg_lo_wm is not above the effective high mark. The stimulus generates frames whose lengths are drawn from 1 to MAX_FRAME_WORDS and always closes the last frame of each phase. It changes the watermarks only after a full drain, and every pair of marks it uses has the low mark below the high mark.

// File: rtl/rxvcb_pkg.sv
package rxvcb_pkg;

  // Number of maximum-size frames the store is dimensioned for
  function automatic int unsigned frames_for(input int unsigned mcast);
    return (mcast != 0) ? 8 : 32;
  endfunction

  // Total words: frame room plus two round trips of headroom
  function automatic int unsigned store_depth(input int unsigned frames,
                                              input int unsigned frame_words,
                                              input int unsigned rtt_words);
    return frames * frame_words + 2 * rtt_words;
  endfunction

endpackage

// File: rtl/rxvcb_rst_sync.sv
module rxvcb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_n_sync <= stage_q;
    end
  end
endmodule

// File: rtl/rxvcb_word_ram.sv
module rxvcb_word_ram #(
  parameter int unsigned WORD_W = 33,
  parameter int unsigned DEPTH  = 320,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [AW-1:0]     rd_addr,
  output logic [WORD_W-1:0] rd_word
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_addr] <= wr_word;
    end
  end

  assign rd_word = mem[rd_addr];
endmodule

// File: rtl/rxvcb_store_ctrl.sv
module rxvcb_store_ctrl #(
  parameter int unsigned DEPTH = 320,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_last,
  input  logic          out_ready,
  input  logic          out_last,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic          out_valid,
  output logic [CW-1:0] occ,
  output logic          overflow
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  function automatic logic [AW-1:0] step_ptr(input logic [AW-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  logic [AW-1:0] wr_q, wr_d, cm_q, cm_d, rd_q, rd_d;
  logic [CW-1:0] occ_q, occ_d, avail_q, avail_d, part_q, part_d;
  logic          drop_q, drop_d, ovf_q, ovf_d;
  logic          full, accept, ovf_hit, pop;

  assign full      = (occ_q == FULL_CNT);
  assign accept    = in_valid && !drop_q && !full;
  assign ovf_hit   = in_valid && !drop_q && full;
  assign out_valid = (avail_q != '0);
  assign pop       = out_valid && out_ready;

  always_comb begin
    wr_d    = wr_q;
    cm_d    = cm_q;
    rd_d    = rd_q;
    part_d  = part_q;
    drop_d  = drop_q;
    ovf_d   = ovf_q;
    occ_d   = occ_q;
    avail_d = avail_q;
    if (accept) begin
      wr_d  = step_ptr(wr_q);
      occ_d = occ_d + 1'b1;
      if (in_last) begin
        cm_d    = step_ptr(wr_q);
        avail_d = avail_d + part_q + 1'b1;
        part_d  = '0;
      end else begin
        part_d = part_q + 1'b1;
      end
    end
    if (ovf_hit) begin
      wr_d   = cm_q;
      occ_d  = occ_d - part_q;
      part_d = '0;
      drop_d = !in_last;
      ovf_d  = 1'b1;
    end
    if (drop_q && in_valid && in_last) begin
      drop_d = 1'b0;
    end
    if (pop) begin
      rd_d    = step_ptr(rd_q);
      occ_d   = occ_d - 1'b1;
      avail_d = avail_d - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= '0;
      cm_q    <= '0;
      rd_q    <= '0;
      part_q  <= '0;
      drop_q  <= 1'b0;
      ovf_q   <= 1'b0;
      occ_q   <= '0;
      avail_q <= '0;
    end else begin
      wr_q    <= wr_d;
      cm_q    <= cm_d;
      rd_q    <= rd_d;
      part_q  <= part_d;
      drop_q  <= drop_d;
      ovf_q   <= ovf_d;
      occ_q   <= occ_d;
      avail_q <= avail_d;
    end
  end

  assign wr_en    = accept;
  assign wr_addr  = wr_q;
  assign rd_addr  = rd_q;
  assign occ      = occ_q;
  assign overflow = ovf_q;

  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q <= FULL_CNT); // R8
  AST_FRAME_WHOLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_last) |=> out_valid); // R3
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q); // R7
  AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q) |-> $past(occ_q) == FULL_CNT); // R7
endmodule

// File: rtl/rxvcb_pause_ctrl.sv
module rxvcb_pause_ctrl #(
  parameter int unsigned DEPTH     = 320,
  parameter int unsigned RTT_WORDS = 32,
  localparam int unsigned CW       = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] occ,
  input  logic [CW-1:0] cfg_hi_wm,
  input  logic [CW-1:0] cfg_lo_wm,
  output logic          pause
);
  localparam logic [CW-1:0] HI_CAP = CW'(DEPTH - RTT_WORDS);

  logic [CW-1:0] hi_eff;
  logic          pause_q, pause_d;

  assign hi_eff = (cfg_hi_wm > HI_CAP) ? HI_CAP : cfg_hi_wm;

  always_comb begin
    pause_d = pause_q;
    if (!pause_q && (occ > hi_eff)) begin
      pause_d = 1'b1;
    end else if (pause_q && (occ < cfg_lo_wm)) begin
      pause_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pause_q <= 1'b0;
    end else begin
      pause_q <= pause_d;
    end
  end

  assign pause = pause_q;

  AST_PAUSE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (!pause_q && occ > HI_CAP) |=> pause_q); // R6
  AST_PAUSE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!pause_q && occ > cfg_hi_wm) |=> pause_q); // R4
  AST_PAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_q && occ >= cfg_lo_wm) |=> pause_q); // R5
  AST_PAUSE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pause_q) |-> $past(occ) < $past(cfg_lo_wm)); // R5
endmodule

// File: rtl/rxvc_wm_buffer.sv
module rxvc_wm_buffer #(
  parameter int unsigned DATA_W          = 32,
  parameter int unsigned MAX_FRAME_WORDS = 8,
  parameter int unsigned MCAST           = 0,
  parameter int unsigned RTT_WORDS       = 32,
  localparam int unsigned FRAMES = rxvcb_pkg::frames_for(MCAST),
  localparam int unsigned DEPTH  = rxvcb_pkg::store_depth(FRAMES, MAX_FRAME_WORDS, RTT_WORDS),
  localparam int unsigned AW     = $clog2(DEPTH),
  localparam int unsigned CW     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last,
  input  logic [CW-1:0]     cfg_hi_wm,
  input  logic [CW-1:0]     cfg_lo_wm,
  output logic              pause,
  output logic              overflow
);
  logic          rst_n_int;
  logic          wr_en;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [CW-1:0] occ;
  logic [DATA_W:0] rd_word;

  rxvcb_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  rxvcb_word_ram #(.WORD_W(DATA_W + 1), .DEPTH(DEPTH)) u_ram (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_word ({in_last, in_data}),
    .rd_addr (rd_addr),
    .rd_word (rd_word)
  );

  rxvcb_store_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .in_valid  (in_valid),
    .in_last   (in_last),
    .out_ready (out_ready),
    .out_last  (out_last),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .rd_addr   (rd_addr),
    .out_valid (out_valid),
    .occ       (occ),
    .overflow  (overflow)
  );

  rxvcb_pause_ctrl #(.DEPTH(DEPTH), .RTT_WORDS(RTT_WORDS)) u_pause (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .occ       (occ),
    .cfg_hi_wm (cfg_hi_wm),
    .cfg_lo_wm (cfg_lo_wm),
    .pause     (pause)
  );

  assign out_data = rd_word[DATA_W-1:0];
  assign out_last = rd_word[DATA_W];

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n_int |-> (!out_valid && !pause && !overflow)); // R1
endmodule

// File: tb/rxvc_wm_buffer_test.sv
module rxvc_wm_buffer_test;
  localparam int MFW   = 8;
  localparam int RTT   = 32;
  localparam int DEPTH = 32 * MFW + 2 * RTT;
  localparam int HICAP = DEPTH - RTT;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b0;
  logic [31:0] in_data = '0;
  logic        out_valid, out_last, pause, overflow;
  logic [31:0] out_data;
  logic [8:0]  cfg_hi_wm = 9'd288, cfg_lo_wm = 9'd32;

  int errors = 0, checks = 0;
  logic [32:0] expq[$];
  logic [32:0] tmpq[$];
  int  m_occ = 0;
  bit  m_pause = 0, m_ovf = 0, m_drop = 0;
  int  rem = 0;

  always #2 clk = ~clk;

  rxvc_wm_buffer uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .cfg_hi_wm(cfg_hi_wm), .cfg_lo_wm(cfg_lo_wm), .pause(pause), .overflow(overflow)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int hi_eff();
    return (int'(cfg_hi_wm) > HICAP) ? HICAP : int'(cfg_hi_wm);
  endfunction

  // One clock cycle of stimulus with the bench model following the requirements
  task automatic step(input bit iv, input logic [31:0] d, input bit il, input bit rdy);
    bit hs;
    @(negedge clk);
    in_valid = iv; in_data = d; in_last = il; out_ready = rdy;
    #1;
    chk(out_valid == (expq.size() != 0), "R3 out_valid", out_valid, expq.size() != 0);
    hs = out_valid && rdy;
    if (hs) chk({out_last, out_data} == expq[0], "R2 word", {out_last, out_data}, expq[0]);
    @(posedge clk);
    if (!m_pause && m_occ > hi_eff()) m_pause = 1;
    else if (m_pause && m_occ < int'(cfg_lo_wm)) m_pause = 0;
    if (iv && !m_drop) begin
      if (m_occ == DEPTH) begin
        m_ovf = 1; m_occ -= tmpq.size(); tmpq.delete(); m_drop = !il;
      end else begin
        m_occ++; tmpq.push_back({il, d});
        if (il) begin
          foreach (tmpq[i]) expq.push_back(tmpq[i]);
          tmpq.delete();
        end
      end
    end else if (iv && m_drop && il) m_drop = 0;
    if (hs) begin m_occ--; void'(expq.pop_front()); end
    #1;
    chk(pause == m_pause, m_pause ? "R5 pause" : "R4 pause", pause, m_pause);
    chk(overflow == m_ovf, "R7 overflow", overflow, m_ovf);
  endtask

  task automatic send_frame(input int len, input bit rdy);
    for (int k = 0; k < len; k++) step(1'b1, $urandom, k == len - 1, rdy);
  endtask

  task automatic drain();
    while (expq.size() != 0) step(1'b0, '0, 1'b0, 1'b1);
    step(1'b0, '0, 1'b0, 1'b1);
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #1;
    chk(!out_valid && !pause && !overflow, "R1 reset outputs", {out_valid, pause, overflow}, 0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk(!out_valid && !pause && !overflow, "R1 after release", {out_valid, pause, overflow}, 0);

    // Random traffic, default marks
    for (int c = 0; c < 3000; c++) begin
      bit iv, il;
      iv = ($urandom % 2) == 0;
      il = 0;
      if (iv) begin
        if (rem == 0) rem = 1 + ($urandom % MFW);
        il = (rem == 1);
        rem--;
      end
      step(iv, $urandom, il, ($urandom % 10) < 7);
    end
    while (rem > 0) begin step(1'b1, $urandom, rem == 1, 1'b1); rem--; end
    drain();

    // R3: partial frame held back
    for (int k = 0; k < 3; k++) step(1'b1, 32'hA0 + k, 1'b0, 1'b0);
    step(1'b0, '0, 1'b0, 1'b0);
    chk(out_valid == 1'b0, "R3 partial hidden", out_valid, 0);
    step(1'b1, 32'hA3, 1'b1, 1'b0);
    step(1'b0, '0, 1'b0, 1'b0);
    chk(out_valid == 1'b1, "R3 complete shown", out_valid, 1);
    drain();

    // R4 / R5: small marks
    cfg_hi_wm = 9'd40; cfg_lo_wm = 9'd10;
    for (int f = 0; f < 6; f++) send_frame(MFW, 1'b0);
    step(1'b0, '0, 1'b0, 1'b0);
    chk(pause == 1'b1, "R4 above high", pause, 1);
    while (m_occ > 10) step(1'b0, '0, 1'b0, 1'b1);
    step(1'b0, '0, 1'b0, 1'b0);
    chk(pause == 1'b1, "R5 held at low mark", pause, 1);
    drain();
    chk(pause == 1'b0, "R5 released", pause, 0);

    // R6: high mark clamped
    cfg_hi_wm = 9'd400; cfg_lo_wm = 9'd32;
    for (int f = 0; f < 36; f++) send_frame(MFW, 1'b0);
    step(1'b0, '0, 1'b0, 1'b0);
    chk(pause == 1'b0, "R6 at clamp", pause, 0);
    send_frame(1, 1'b0);
    step(1'b0, '0, 1'b0, 1'b0);
    chk(pause == 1'b1, "R6 above clamp", pause, 1);

    // R8: fill exactly DEPTH with mixed lengths
    send_frame(8, 1'b0); send_frame(8, 1'b0); send_frame(8, 1'b0);
    send_frame(3, 1'b0); send_frame(4, 1'b0);
    chk(m_occ == DEPTH && overflow == 1'b0, "R8 full no overflow", overflow, 0);

    // R7: overflow drops whole frames
    send_frame(1, 1'b0);
    chk(overflow == 1'b1, "R7 sticky set", overflow, 1);
    for (int k = 0; k < 3; k++) step(1'b0, '0, 1'b0, 1'b1);
    send_frame(5, 1'b0);
    chk(expq.size() == DEPTH - 3, "R7 partial rolled back", expq.size(), DEPTH - 3);
    drain();
    send_frame(4, 1'b0);
    step(1'b0, '0, 1'b0, 1'b0);
    chk(out_valid == 1'b1, "R7 later frame passes", out_valid, 1);
    drain();
    chk(overflow == 1'b1, "R7 still sticky", overflow, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule